// File: doc/BRIEF.md
# Pipeline Write-Completion Checker with Debug Visibility

This block watches one timing rule of a five-stage pipeline: a write that enters the first stage must complete at the write-back stage exactly four cycles later. Each write-issue strobe starts an activation. The write-complete strobe four cycles later decides whether that activation passes or fails. A write-complete strobe that no activation is waiting for is also a failure. The checker is built from plain registers and gates, so it can sit in silicon next to the pipeline it observes.

The block exposes its internal state in several ways. A single pulse output reports either failures (normal mode) or successful completions (completion mode). An activity output shows whether any activation is in flight. A vacuity flag shows that no write has been issued since reset or the last clear. Two saturating counters record failures and successful matches. In threaded mode, each activation gets its own tracking thread, so a miss is reported on that thread's flag apart from the other writes in flight. When every thread is busy, a sticky overflow flag is set and a shared shift-register tracker checks the activation instead.

Top module: `pwc_write_checker`

## Requirements
- R1: A write-issue sampled at clock edge E starts an activation. The activation passes if write-complete is sampled high at edge E+4 and fails otherwise. A write-complete at an edge where no activation is due is a failure on its own.
- R2: `chk_pulse` is registered. It is high for one cycle after an edge at which the selected event occurred. With `success_mode`=0 the event is a failure; with `success_mode`=1 the event is a pass.
- R3: `active` is high while any shift-register stage or any thread holds an activation, and low once every activation has been resolved.
- R4: `vacuous` is 1 after reset and after a clear. It drops to 0 after the first edge at which write-issue is sampled without a clear.
- R5: `fail_cnt` is 16 bits wide. It adds one at each edge with a failure and holds at 65535 once it reaches that value.
- R6: `cover_cnt` is 16 bits wide. It adds one at each edge with a pass, as the pass occurs, and holds at 65535.
- R7: With `thread_mode`=1, each new activation goes to the next free thread in round-robin order, starting at thread 0. Bit i of `thr_fail` pulses for one cycle after thread i's activation misses its write-complete. A stray write-complete raises no thread flag. With `thread_mode`=0 all bits of `thr_fail` stay 0.
- R8: In threaded mode, a write-issue that finds all threads busy sets `overflow`, which stays set until reset. That activation is still checked by the shared tracker, and its result reaches `chk_pulse` and the counters but no thread flag. A thread whose activation is due in the same cycle counts as free.
- R9: A synchronous `clr` zeroes both counters and sets `vacuous` for the next cycle, taking priority over any increment. It leaves `overflow` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the counters and the vacuity flag |
| wr_issue | input | 1 | A write is entering pipeline stage 1 |
| wr_done | input | 1 | A write is completing at write-back |
| success_mode | input | 1 | 0: `chk_pulse` reports failures; 1: it reports passes |
| thread_mode | input | 1 | 1: activations go to per-activation threads |
| chk_pulse | output | 1 | Registered failure or success pulse |
| active | output | 1 | An activation is in flight |
| vacuous | output | 1 | No write issued since reset or clear |
| overflow | output | 1 | Sticky: a write found all threads busy |
| fail_cnt | output | 16 | Saturating failure count |
| cover_cnt | output | 16 | Saturating pass count |
| thr_fail | output | 3 | Per-thread miss pulse |

## Verification
The bench covers the following corner cases:
- A stray write-complete between two activations. A design that only checked due slots would miss this failure.
- A lost write-complete. This must show up as a failure pulse in normal mode and as a silent cycle in completion mode.
- Four back-to-back writes with three threads. This checks round-robin dispatch, checks that the miss lands on the flag of thread 1, and checks that the fourth write sets overflow and is still judged by the shared tracker. A design that dropped overflowed activations would count one failure too few.
- Both counters driven to their limits. A counter that wraps to zero instead of holding fails the check, as does a clear that leaves `vacuous` low or wrongly clears `overflow`.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  // saturating increment, kept as a function so the arithmetic is explicit
  function automatic logic [31:0] sat_next(input logic [31:0] cur,
                                           input logic [31:0] top,
                                           input logic        inc);
    if (inc && cur != top) return cur + 32'd1;
    return cur;
  endfunction

  // true when a thread of the given age is at its check slot
  function automatic logic at_slot(input int unsigned age, input int unsigned lat);
    return age == lat - 1;
  endfunction
endpackage

// File: rtl/pwc_shift_tracker.sv
module pwc_shift_tracker #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic due,
  output logic busy_any
);
  logic [LAT-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[LAT-2:0], start};
  end

  assign due      = stage_q[LAT-1];
  assign busy_any = |stage_q;
endmodule

// File: rtl/pwc_thread_pool.sv
module pwc_thread_pool
  import pwc_pkg::*;
#(
  parameter int THREADS = 3,
  parameter int LAT     = 4,
  parameter int AGE_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               start,
  input  logic               wr_done,
  output logic               accepted,
  output logic               due_any,
  output logic               busy_any,
  output logic [THREADS-1:0] thr_fail
);
  localparam int RR_W = (THREADS > 1) ? $clog2(THREADS) : 1;

  logic [THREADS-1:0] busy_q, due_v, free_v, take_v;
  logic [RR_W-1:0]    rr_q, sel;
  logic               found;

  assign free_v = ~busy_q | due_v;

  // first free thread at or after the round-robin pointer
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < THREADS; k++) begin
      int idx;
      idx = (int'(rr_q) + k) % THREADS;
      if (!found && free_v[idx]) begin
        found = 1'b1;
        sel   = RR_W'(idx);
      end
    end
  end

  assign accepted = en & start & found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else if (accepted)
      rr_q <= (int'(sel) == THREADS - 1) ? '0 : sel + RR_W'(1);
  end

  for (genvar i = 0; i < THREADS; i++) begin : g_thr
    logic [AGE_W-1:0] age_q;
    assign due_v[i]  = busy_q[i] & at_slot(int'(age_q), LAT);
    assign take_v[i] = accepted & (int'(sel) == i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[i]   <= 1'b0;
        age_q       <= '0;
        thr_fail[i] <= 1'b0;
      end else begin
        thr_fail[i] <= due_v[i] & ~wr_done;
        if (take_v[i]) begin
          busy_q[i] <= 1'b1;
          age_q     <= '0;
        end else if (due_v[i]) begin
          busy_q[i] <= 1'b0;
        end else if (busy_q[i]) begin
          age_q <= age_q + AGE_W'(1);
        end
      end
    end
  end

  assign due_any  = |due_v;
  assign busy_any = |busy_q;
endmodule

// File: rtl/pwc_sat_counter.sv
module pwc_sat_counter
  import pwc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [31:0] TOP = 32'((64'd1 << W) - 64'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= W'(sat_next(32'(cnt), TOP, inc));
  end
endmodule

// File: rtl/pwc_write_checker.sv
module pwc_write_checker #(
  parameter int LAT     = 4,
  parameter int THREADS = 3,
  parameter int AGE_W   = 3,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_issue,
  input  logic               wr_done,
  input  logic               success_mode,
  input  logic               thread_mode,
  output logic               chk_pulse,
  output logic               active,
  output logic               vacuous,
  output logic               overflow,
  output logic [CNT_W-1:0]   fail_cnt,
  output logic [CNT_W-1:0]   cover_cnt,
  output logic [THREADS-1:0] thr_fail
);
  // named internal events, visible to the bound checker
  logic thr_accept, thr_due, thr_busy;
  logic sh_start, sh_due, sh_busy;
  logic due_any, pass_ev, fail_ev, no_room;

  pwc_thread_pool #(.THREADS(THREADS), .LAT(LAT), .AGE_W(AGE_W)) u_pool (
    .clk(clk), .rst_n(rst_n), .en(thread_mode), .start(wr_issue),
    .wr_done(wr_done), .accepted(thr_accept), .due_any(thr_due),
    .busy_any(thr_busy), .thr_fail(thr_fail)
  );

  // shared tracker: every activation in plain mode, overflow ones in threaded mode
  assign sh_start = wr_issue & ~(thread_mode & thr_accept);
  assign no_room  = thread_mode & wr_issue & ~thr_accept;

  pwc_shift_tracker #(.LAT(LAT)) u_shared (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .due(sh_due), .busy_any(sh_busy)
  );

  assign due_any = sh_due | thr_due;
  assign pass_ev = due_any & wr_done;
  assign fail_ev = due_any ^ wr_done;
  assign active  = sh_busy | thr_busy;

  pwc_sat_counter #(.W(CNT_W)) u_fail_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(fail_ev), .cnt(fail_cnt)
  );
  pwc_sat_counter #(.W(CNT_W)) u_cover_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(pass_ev), .cnt(cover_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_pulse <= 1'b0;
      vacuous   <= 1'b1;
      overflow  <= 1'b0;
    end else begin
      chk_pulse <= success_mode ? pass_ev : fail_ev;
      if (clr)           vacuous <= 1'b1;
      else if (wr_issue) vacuous <= 1'b0;
      if (no_room)       overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/pwc_write_checker_sva.sv
module pwc_write_checker_sva #(
  parameter int THREADS = 3,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               wr_issue,
  input logic               success_mode,
  input logic               chk_pulse,
  input logic               active,
  input logic               vacuous,
  input logic               overflow,
  input logic [CNT_W-1:0]   fail_cnt,
  input logic [CNT_W-1:0]   cover_cnt,
  input logic [THREADS-1:0] thr_fail,
  input logic               pass_ev,
  input logic               fail_ev
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r1_pass_fail_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_ev && fail_ev));

  a_r2_fail_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_ev && !success_mode) |=> chk_pulse);

  a_r2_success_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_ev && success_mode) |=> chk_pulse);

  a_r3_active_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    wr_issue |=> active);

  a_r4_issue_clears_vacuity: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_issue && !clr) |=> !vacuous);

  a_r5_fail_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && fail_ev && fail_cnt != CMAX) |=> fail_cnt == $past(fail_cnt) + 1'b1);

  a_r6_cover_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && pass_ev && cover_cnt != CMAX) |=> cover_cnt == $past(cover_cnt) + 1'b1);

  a_r7_one_thread_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(thr_fail));

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fail_cnt == '0 && cover_cnt == '0 && vacuous));
endmodule

bind pwc_write_checker pwc_write_checker_sva #(.THREADS(THREADS), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .clr(clr), .wr_issue(wr_issue),
  .success_mode(success_mode), .chk_pulse(chk_pulse), .active(active),
  .vacuous(vacuous), .overflow(overflow), .fail_cnt(fail_cnt),
  .cover_cnt(cover_cnt), .thr_fail(thr_fail), .pass_ev(pass_ev), .fail_ev(fail_ev)
);

// File: tb/pwc_write_checker_tb_top.sv
`timescale 1ns/1ps
module pwc_write_checker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic wr_issue = 1'b0, wr_done = 1'b0, success_mode = 1'b0, thread_mode = 1'b0;
  logic chk_pulse, active, vacuous, overflow;
  logic [15:0] fail_cnt, cover_cnt;
  logic [2:0]  thr_fail;
  int n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  pwc_write_checker dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_issue(wr_issue), .wr_done(wr_done),
    .success_mode(success_mode), .thread_mode(thread_mode), .chk_pulse(chk_pulse),
    .active(active), .vacuous(vacuous), .overflow(overflow), .fail_cnt(fail_cnt),
    .cover_cnt(cover_cnt), .thr_fail(thr_fail)
  );

  // per cycle: [7] success_mode [6] thread_mode [5] wr_issue [4] wr_done
  //            [3] expected chk_pulse [2:0] expected thr_fail, both after the edge
  localparam logic [7:0] VEC [0:19] = '{
    8'b0010_0000, 8'b0000_0000, 8'b0000_0000, 8'b0000_0000,
    8'b0001_0000, 8'b0001_1000, 8'b0010_0000, 8'b0000_0000,
    8'b0000_0000, 8'b0000_0000, 8'b0000_1000, 8'b1110_0000,
    8'b1110_0000, 8'b1110_0000, 8'b1110_0000, 8'b1101_1000,
    8'b1100_0010, 8'b1101_1000, 8'b1100_0000, 8'b1100_0000
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_500_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // reset state
    check("R4 vacuous after reset", vacuous, 1);
    check("R3 idle after reset", active, 0);
    check("R5 fail_cnt reset", fail_cnt, 0);
    check("R6 cover_cnt reset", cover_cnt, 0);
    check("R8 overflow reset", overflow, 0);

    // table walk: plain mode, then threaded success mode with overflow
    for (int k = 0; k < 20; k++) begin
      {success_mode, thread_mode, wr_issue, wr_done} = VEC[k][7:4];
      step(1);
      check($sformatf("R1 R2 chk_pulse row %0d", k), chk_pulse, VEC[k][3]);
      check($sformatf("R7 thr_fail row %0d", k), thr_fail, VEC[k][2:0]);
      if (k == 0) begin
        check("R3 active after issue", active, 1);
        check("R4 vacuity cleared by issue", vacuous, 0);
      end
      if (k == 14) check("R8 overflow on full pool", overflow, 1);
    end
    {success_mode, thread_mode, wr_issue, wr_done} = 4'b0;
    step(1);
    check("R3 idle after all resolved", active, 0);
    check("R5 fail count incl overflow miss", fail_cnt, 4);
    check("R6 cover count", cover_cnt, 3);
    check("R8 overflow sticky", overflow, 1);

    // clear
    clr = 1'b1; wr_done = 1'b1;
    step(1);
    clr = 1'b0; wr_done = 1'b0;
    check("R9 clear fail_cnt over increment", fail_cnt, 0);
    check("R9 clear cover_cnt", cover_cnt, 0);
    check("R9 clear sets vacuous", vacuous, 1);
    check("R9 clear keeps overflow", overflow, 1);

    // failure counter saturation via stray completions
    wr_done = 1'b1;
    step(65540);
    wr_done = 1'b0;
    check("R5 fail_cnt saturates", fail_cnt, 65535);
    check("R4 no issue keeps vacuous", vacuous, 1);

    // cover counter saturation: issue and complete every cycle
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    wr_issue = 1'b1; wr_done = 1'b1;
    step(4);
    check("R5 stray before first due", fail_cnt, 4);
    check("R6 cover before first due", cover_cnt, 0);
    step(65541);
    wr_issue = 1'b0; wr_done = 1'b0;
    check("R6 cover_cnt saturates", cover_cnt, 65535);
    check("R7 no thread flags in plain mode", thr_fail, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule